// File: doc/BRIEF.md
# Ternary Classifier Matcher and Message Builder

This block holds one rule of a learning classifier system: two conditions and one action. Each is a string of symbols from {0, 1, #}, and each symbol takes two storage bits. Binary messages arrive one per cycle during a matching pass. Each message is compared against both conditions at the same time. A message bit of 0 tests the low storage bit of a symbol and a bit of 1 tests the high bit, so a stored # (both bits set) accepts either value.

The rule becomes active once each of its two conditions has been satisfied by some message in the current pass. A pass begins with a start strobe. The block keeps a copy of the first message in the pass that matched the first condition. While the rule is active, it builds the outgoing message from that copy and the action: fixed action symbols are copied, and # symbols pass the copied message's bit through. Matches against internal messages, which were posted by the system in its previous cycle, are tallied in a saturating counter.

Top module: `tcm_matcher`

## Requirements
- R1: Symbol i of a condition or action is held in bits [2i+1:2i]. The code 01 means 0, 10 means 1 and 11 means #. Message bit i matches symbol i when the bit is 0 and bit 2i is set, or when the bit is 1 and bit 2i+1 is set. A condition matches when all of its symbols match.
- R2: A condition that holds a symbol coded 00 never matches any message.
- R3: `active` is high exactly when both conditions have matched at least one message since the last start or load.
- R4: `match_vld` is high in the cycle after a message is presented with `msg_vld`, and only when that message matched at least one condition.
- R5: While active, bit i of `new_msg` is 0 for action code 01, 1 for action code 10 and 0 for action code 00. For action code 11 it is bit i of the first message in the pass that matched the first condition.
- R6: Each presented message with `msg_int` high that matches at least one condition adds one to `int_hits`. A message with `msg_int` low leaves it unchanged.
- R7: `int_hits` holds at its all-ones value instead of wrapping.
- R8: A start without a message clears `active`. A message presented together with start belongs to the new pass. A load clears `int_hits` and `active`, and a message presented in the same cycle as a load is ignored.
- R9: After reset, `match_vld`, `active` and `int_hits` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load the rule from the three load buses |
| ld_cond_a | input | 2*SYM | First condition, two bits per symbol |
| ld_cond_b | input | 2*SYM | Second condition, two bits per symbol |
| ld_act | input | 2*SYM | Action template, two bits per symbol |
| start | input | 1 | Begin a new matching pass |
| msg_vld | input | 1 | A message is presented this cycle |
| msg_int | input | 1 | The presented message is internal |
| msg | input | SYM | Binary message |
| match_vld | output | 1 | The previous message matched a condition |
| active | output | 1 | Both conditions are satisfied in this pass |
| int_hits | output | CNT_W | Saturating count of internal-message matches |
| new_msg | output | SYM | Built message, meaningful while active |

## Verification
Every result is registered once. A message or load driven before a clock edge therefore shows up on `match_vld`, `active`, `int_hits` and `new_msg` right after that edge, and `new_msg` follows `active` combinationally. The bench drives inputs at the falling edge, releases them at the next falling edge, and samples the outputs there. That sample point is half a period after the edge that registered the result. The sweep starts a new pass with every message, so each sample depends only on the loaded rule, that one message and the running count.

// File: rtl/tcm_matcher.sv
module tcm_matcher #(
  parameter int SYM   = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [2*SYM-1:0] ld_cond_a,
  input  logic [2*SYM-1:0] ld_cond_b,
  input  logic [2*SYM-1:0] ld_act,
  input  logic             start,
  input  logic             msg_vld,
  input  logic             msg_int,
  input  logic [SYM-1:0]   msg,
  output logic             match_vld,
  output logic             active,
  output logic [CNT_W-1:0] int_hits,
  output logic [SYM-1:0]   new_msg
);

  localparam int CW = 2 * SYM;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CW-1:0]  cond_a, cond_b, act;
  logic [SYM-1:0] sym_a, sym_b, held;
  logic           hit_a, hit_b;

  for (genvar i = 0; i < SYM; i++) begin : g_sym
    assign sym_a[i]   = msg[i] ? cond_a[2*i+1] : cond_a[2*i];
    assign sym_b[i]   = msg[i] ? cond_b[2*i+1] : cond_b[2*i];
    assign new_msg[i] = (act[2*i+1] & act[2*i]) ? held[i] : (act[2*i+1] & ~act[2*i]);
  end

  wire m_a  = &sym_a;
  wire m_b  = &sym_b;
  wire take = msg_vld & (m_a | m_b);

  assign active = hit_a & hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_a    <= '0;
      cond_b    <= '0;
      act       <= '0;
      held      <= '0;
      hit_a     <= 1'b0;
      hit_b     <= 1'b0;
      match_vld <= 1'b0;
      int_hits  <= '0;
    end else if (ld_en) begin
      cond_a    <= ld_cond_a;
      cond_b    <= ld_cond_b;
      act       <= ld_act;
      held      <= '0;
      hit_a     <= 1'b0;
      hit_b     <= 1'b0;
      match_vld <= 1'b0;
      int_hits  <= '0;
    end else begin
      match_vld <= take;
      hit_a     <= (hit_a & ~start) | (msg_vld & m_a);
      hit_b     <= (hit_b & ~start) | (msg_vld & m_b);
      if (msg_vld && m_a && (start || !hit_a))
        held <= msg;
      if (take && msg_int && int_hits != CNT_MAX)
        int_hits <= int_hits + 1'b1;
    end
  end

endmodule

module tcm_matcher_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic             start,
  input logic             msg_vld,
  input logic             msg_int,
  input logic             match_vld,
  input logic             active,
  input logic [CNT_W-1:0] int_hits
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_match_after_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> $past(msg_vld));

  p_active_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(msg_vld) && !$past(ld_en)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> (int_hits == $past(int_hits) || int_hits == $past(int_hits) + 1));

  p_ext_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && !msg_int && !ld_en) |=> $stable(int_hits));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_hits == CNT_MAX && !ld_en) |=> int_hits == CNT_MAX);

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (int_hits == '0 && !active && !match_vld));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !msg_vld && !ld_en) |=> !active);

endmodule

bind tcm_matcher tcm_matcher_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .start(start), .msg_vld(msg_vld),
  .msg_int(msg_int), .match_vld(match_vld), .active(active), .int_hits(int_hits)
);

// File: tb/tcm_matcher_bench.sv
module tcm_matcher_bench;
  localparam int SYM = 4;
  localparam int CNT_W = 3;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, start = 1'b0, msg_vld = 1'b0, msg_int = 1'b0;
  logic [2*SYM-1:0] ld_cond_a = '0, ld_cond_b = '0, ld_act = '0;
  logic [SYM-1:0] msg = '0;
  logic match_vld, active;
  logic [CNT_W-1:0] int_hits;
  logic [SYM-1:0] new_msg;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tcm_matcher #(.SYM(SYM), .CNT_W(CNT_W)) u_tcm_matcher (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_cond_a(ld_cond_a),
    .ld_cond_b(ld_cond_b), .ld_act(ld_act), .start(start), .msg_vld(msg_vld),
    .msg_int(msg_int), .msg(msg), .match_vld(match_vld), .active(active),
    .int_hits(int_hits), .new_msg(new_msg)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] enc(input logic [3:0] care, input logic [3:0] val);
    logic [7:0] r;
    for (int i = 0; i < 4; i++)
      r[2*i +: 2] = !care[i] ? 2'b11 : (val[i] ? 2'b10 : 2'b01);
    return r;
  endfunction

  function automatic bit fm(input logic [7:0] c, input logic [3:0] m);
    bit ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      int code = int'(c[2*i +: 2]);
      if (!(code == 3 || (code == 2 && m[i]) || (code == 1 && !m[i]))) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [3:0] build(input logic [7:0] a, input logic [3:0] m);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      int code = int'(a[2*i +: 2]);
      r[i] = (code == 3) ? m[i] : (code == 2);
    end
    return r;
  endfunction

  task automatic load(input logic [7:0] a, input logic [7:0] b, input logic [7:0] ac);
    @(negedge clk);
    ld_en = 1'b1; ld_cond_a = a; ld_cond_b = b; ld_act = ac;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic send(input logic [3:0] m, input bit internal, input bit st);
    @(negedge clk);
    msg = m; msg_vld = 1'b1; msg_int = internal; start = st;
    @(negedge clk);
    msg_vld = 1'b0; start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] sw;
    int expcnt;
    bit ea, eb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(match_vld == 0, "R9 match_vld", match_vld, 0);
    chk(active == 0, "R9 active", active, 0);
    chk(int_hits == 0, "R9 int_hits", int_hits, 0);

    // R3/R5: two messages satisfy the two conditions separately
    load(enc(4'b1111, 4'b1010), enc(4'b0011, 4'b0001), enc(4'b1100, 4'b0100));
    send(4'b1010, 1'b1, 1'b1);
    chk(match_vld == 1, "R4 first msg", match_vld, 1);
    chk(active == 0, "R3 one condition only", active, 0);
    chk(int_hits == 1, "R6 internal count", int_hits, 1);
    send(4'b0001, 1'b1, 1'b0);
    chk(active == 1, "R3 both conditions", active, 1);
    chk(int_hits == 2, "R6 internal count", int_hits, 2);
    chk(new_msg == 4'b0110, "R5 built from first A match", new_msg, 4'b0110);
    send(4'b1010, 1'b0, 1'b0);
    chk(new_msg == 4'b0110, "R5 held copy kept", new_msg, 4'b0110);
    chk(int_hits == 2, "R6 external not counted", int_hits, 2);
    send(4'b0110, 1'b1, 1'b0);
    chk(match_vld == 0, "R4 no match", match_vld, 0);
    chk(int_hits == 2, "R6 unmatched not counted", int_hits, 2);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(active == 0, "R8 start clears active", active, 0);
    // R8 load ignores same-cycle message
    @(negedge clk);
    ld_en = 1'b1; ld_cond_a = 8'hFF; ld_cond_b = 8'hFF; ld_act = 8'hFF;
    msg = 4'b0101; msg_vld = 1'b1; msg_int = 1'b1; start = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; msg_vld = 1'b0; start = 1'b0;
    chk(match_vld == 0, "R8 load wins match_vld", match_vld, 0);
    chk(active == 0, "R8 load wins active", active, 0);
    chk(int_hits == 0, "R8 load clears count", int_hits, 0);

    // R2 illegal code 00 never matches
    load(8'b11_11_11_00, 8'hFF, 8'hFF);
    for (int m = 0; m < 16; m++) begin
      send(m[3:0], 1'b0, 1'b1);
      chk(active == 0, "R2 illegal symbol", active, 0);
      chk(match_vld == 1, "R4 other condition", match_vld, 1);
    end

    // R1/R3/R4/R5/R6/R7 sweep of every legal and illegal code pattern
    for (int p = 0; p < 256; p++) begin
      sw = {p[3:0], p[7:4]};
      load(p[7:0], sw, p[7:0]);
      expcnt = 0;
      for (int m = 0; m < 16; m++) begin
        send(m[3:0], m[0], 1'b1);
        ea = fm(p[7:0], m[3:0]);
        eb = fm(sw, m[3:0]);
        chk(match_vld == (ea | eb), "R1 R4 match", match_vld, int'(ea | eb));
        chk(active == (ea & eb), "R3 active", active, int'(ea & eb));
        if (ea && eb)
          chk(new_msg == build(p[7:0], m[3:0]), "R5 built message", new_msg, build(p[7:0], m[3:0]));
        if (m[0] && (ea || eb) && expcnt < CMAX) expcnt++;
        chk(int_hits == expcnt, (expcnt == CMAX) ? "R7 saturate" : "R6 count", int_hits, expcnt);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule